// File: doc/BRIEF.md
# Processor Timer Unit

This block gives an embedded processor core its timing services. The block holds four timers. A free-running time base counts system clocks. A down-counting interval timer can reload itself, and software uses it to produce the operating system tick. A fixed interval timer fires each time a chosen time base bit rises. A two-stage watchdog raises an interrupt on its first expiry and a reset request on its second. All four timers share one clock, and the time base advances on every cycle.

Software reaches the block through a simple write port and a read port. One write loads the interval timer. One packed control word selects the periods, the enables, the reset type and auto-reload. A status word is cleared by writing ones to the bits to be cleared. The interrupt outputs are levels. The reset request carries a two-bit code that names the kind of reset wanted.

Top module: `cpu_timer_unit`

## Requirements
- R1: After a synchronous reset every counter, the control word, the status word, `rd_data`, all three interrupts and `rst_req` are zero.
- R2: The time base increases by exactly one on every clock. Two reads of select 3 on consecutive cycles differ by one.
- R3: `rd_data` is registered. One cycle after `rd_addr` is presented, it shows the state held before that edge. The codes are 0 = interval count, 1 = control word, 2 = status word (bits 3:0, zero-extended), 3 = time base.
- R4: A write to address 0 loads both the interval count and its reload value, and this load wins over the count's own update in that cycle. A nonzero count decrements once per clock. A count of zero stays zero unless it is written again.
- R5: When the interval count steps from 1 to 0, status bit 1 is set. If control bit 22 (auto-reload) is set, the count takes the reload value instead of 0, so one event occurs every N clocks for a load of N.
- R6: Control bits 25:24 = s give the fixed timer a period of 2^(FIT_EXP0+EXP_STEP*s) clocks. Its event occurs when time base bit (FIT_EXP0+EXP_STEP*s-1) rises from 0 to 1, and the event sets status bit 0.
- R7: Control bits 31:30 = s select the watchdog period 2^(WDG_EXP0+EXP_STEP*s) in the same way. Each watchdog expiry sets status bits 2 and 3.
- R8: If the watchdog expires while status bit 3 was already set before that edge, `rst_req` takes the value of control bits 29:28 (0 none, 1 core, 2 chip, 3 system). The code 0 requests nothing. A nonzero request holds until reset.
- R9: A write to address 2 clears exactly the status bits written as 1 and leaves the bits written as 0 unchanged. The clear wins over an event that sets the same bit in the same cycle.
- R10: `irq_fit` equals status bit 0 AND control bit 23. `irq_pit` equals status bit 1 AND control bit 26. `irq_wdg` equals status bit 2 AND control bit 27. Each is valid in the same cycle as the status and control state.
- R11: A write to address 1 stores all 32 bits of the control word, and reading select 1 returns them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Write target: 0 interval, 1 control, 2 status clear, 3 none |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read select |
| rd_data | output | 32 | Registered read data |
| irq_fit | output | 1 | Fixed interval timer interrupt level |
| irq_pit | output | 1 | Interval timer interrupt level |
| irq_wdg | output | 1 | Watchdog interrupt level |
| rst_req | output | 2 | Reset request code, 0 when idle |

## Verification
A time base that slips by even one count shows up in two places. The select-3 read is wrong on the next cycle. Every fixed timer and watchdog event then lands a cycle off, so an interrupt level changes on the wrong edge. A corrupted interval count or reload value moves the tick edge on `irq_pit`, and this is visible within one period. A wrong two-stage watchdog state either asserts `rst_req` one expiry early or never asserts it. The bench's reference model compares all of these outputs on every cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int TSR_W   = 4;
  localparam int TSR_FIT = 0;
  localparam int TSR_PIT = 1;
  localparam int TSR_WDG = 2;
  localparam int TSR_ARM = 3;

  localparam int CTL_WDG_PER = 30;
  localparam int CTL_WDG_KND = 28;
  localparam int CTL_WDG_IE  = 27;
  localparam int CTL_PIT_IE  = 26;
  localparam int CTL_FIT_PER = 24;
  localparam int CTL_FIT_IE  = 23;
  localparam int CTL_AUTO_RL = 22;

  typedef enum logic [1:0] {
    SEL_PIT = 2'd0,
    SEL_CTL = 2'd1,
    SEL_STS = 2'd2,
    SEL_TB  = 2'd3
  } reg_sel_e;

endpackage

// File: rtl/tmr_tap_edge.sv
module tmr_tap_edge (
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] taps,
  input  logic [1:0] sel,
  output logic       fire
);
  logic cur;
  logic prev_q;

  assign cur  = taps[sel];
  assign fire = cur & ~prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= cur;
  end

  a_r6_no_back_to_back: assert property (@(posedge clk) disable iff (rst)
    fire |=> !fire);
endmodule

// File: rtl/tmr_pit.sv
module tmr_pit #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         auto_rl,
  output logic [W-1:0] cnt,
  output logic         fire
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] reload_q;
  logic         at_one;

  assign at_one = (cnt_q == W'(1));
  assign fire   = at_one & ~load;
  assign cnt    = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      reload_q <= '0;
    end else if (load) begin
      cnt_q    <= load_val;
      reload_q <= load_val;
    end else if (at_one) begin
      cnt_q <= auto_rl ? reload_q : '0;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - W'(1);
    end
  end

  a_r4_zero_holds: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == '0 && !load) |=> cnt_q == '0);
  a_r4_counts_down: assert property (@(posedge clk) disable iff (rst)
    (cnt_q > W'(1) && !load) |=> cnt_q == $past(cnt_q) - W'(1));
  a_r5_reload: assert property (@(posedge clk) disable iff (rst)
    (at_one && !load && auto_rl) |=> cnt_q == $past(reload_q));
endmodule

// File: rtl/tmr_wdg_reset.sv
module tmr_wdg_reset (
  input  logic       clk,
  input  logic       rst,
  input  logic       expire,
  input  logic       armed,
  input  logic [1:0] kind,
  output logic [1:0] req
);
  logic [1:0] req_q;

  assign req = req_q;

  always_ff @(posedge clk) begin
    if (rst) req_q <= 2'd0;
    else if (req_q == 2'd0 && expire && armed) req_q <= kind;
  end

  a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
    (req_q != 2'd0) |=> req_q == $past(req_q));
  a_r8_needs_second_stage: assert property (@(posedge clk) disable iff (rst)
    (req_q == 2'd0 && !(expire && armed)) |=> req_q == 2'd0);
endmodule

// File: rtl/cpu_timer_unit.sv
module cpu_timer_unit
  import tmr_pkg::*;
#(
  parameter int TB_W     = 32,
  parameter int PIT_W    = 32,
  parameter int FIT_EXP0 = 9,
  parameter int WDG_EXP0 = 17,
  parameter int EXP_STEP = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [1:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic [1:0]  rd_addr,
  output logic [31:0] rd_data,
  output logic        irq_fit,
  output logic        irq_pit,
  output logic        irq_wdg,
  output logic [1:0]  rst_req
);
  localparam int NTAP = 4;

  logic [TB_W-1:0]  tb_q;
  logic [31:0]      tcr_q;
  logic [TSR_W-1:0] tsr_q, tsr_set, tsr_clr, tsr_d;
  logic [NTAP-1:0]  fit_taps, wdg_taps;
  logic             fit_fire, wdg_fire, pit_fire;
  logic [PIT_W-1:0] pit_cnt;
  logic             wr_pit, wr_ctl, wr_sts;
  logic [31:0]      rd_q;
  logic             irq_fit_q, irq_pit_q, irq_wdg_q;
  logic             fit_ie_d, pit_ie_d, wdg_ie_d;

  assign wr_pit = wr_en && (wr_addr == SEL_PIT);
  assign wr_ctl = wr_en && (wr_addr == SEL_CTL);
  assign wr_sts = wr_en && (wr_addr == SEL_STS);

  for (genvar g = 0; g < NTAP; g++) begin : g_tap
    assign fit_taps[g] = tb_q[FIT_EXP0 - 1 + EXP_STEP * g];
    assign wdg_taps[g] = tb_q[WDG_EXP0 - 1 + EXP_STEP * g];
  end

  tmr_tap_edge u_fit_edge (
    .clk  (clk),
    .rst  (rst),
    .taps (fit_taps),
    .sel  (tcr_q[CTL_FIT_PER +: 2]),
    .fire (fit_fire)
  );

  tmr_tap_edge u_wdg_edge (
    .clk  (clk),
    .rst  (rst),
    .taps (wdg_taps),
    .sel  (tcr_q[CTL_WDG_PER +: 2]),
    .fire (wdg_fire)
  );

  tmr_pit #(.W(PIT_W)) u_pit (
    .clk      (clk),
    .rst      (rst),
    .load     (wr_pit),
    .load_val (wr_data[PIT_W-1:0]),
    .auto_rl  (tcr_q[CTL_AUTO_RL]),
    .cnt      (pit_cnt),
    .fire     (pit_fire)
  );

  tmr_wdg_reset u_wdg (
    .clk    (clk),
    .rst    (rst),
    .expire (wdg_fire),
    .armed  (tsr_q[TSR_ARM]),
    .kind   (tcr_q[CTL_WDG_KND +: 2]),
    .req    (rst_req)
  );

  always_comb begin
    tsr_set = '0;
    tsr_set[TSR_FIT] = fit_fire;
    tsr_set[TSR_PIT] = pit_fire;
    tsr_set[TSR_WDG] = wdg_fire;
    tsr_set[TSR_ARM] = wdg_fire;
    tsr_clr = wr_sts ? wr_data[TSR_W-1:0] : '0;
    tsr_d   = (tsr_q | tsr_set) & ~tsr_clr;
    fit_ie_d = wr_ctl ? wr_data[CTL_FIT_IE] : tcr_q[CTL_FIT_IE];
    pit_ie_d = wr_ctl ? wr_data[CTL_PIT_IE] : tcr_q[CTL_PIT_IE];
    wdg_ie_d = wr_ctl ? wr_data[CTL_WDG_IE] : tcr_q[CTL_WDG_IE];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tb_q      <= '0;
      tcr_q     <= '0;
      tsr_q     <= '0;
      rd_q      <= '0;
      irq_fit_q <= 1'b0;
      irq_pit_q <= 1'b0;
      irq_wdg_q <= 1'b0;
    end else begin
      tb_q  <= tb_q + TB_W'(1);
      tsr_q <= tsr_d;
      if (wr_ctl) tcr_q <= wr_data;
      unique case (rd_addr)
        SEL_PIT: rd_q <= 32'(pit_cnt);
        SEL_CTL: rd_q <= tcr_q;
        SEL_STS: rd_q <= 32'(tsr_q);
        default: rd_q <= 32'(tb_q);
      endcase
      irq_fit_q <= tsr_d[TSR_FIT] & fit_ie_d;
      irq_pit_q <= tsr_d[TSR_PIT] & pit_ie_d;
      irq_wdg_q <= tsr_d[TSR_WDG] & wdg_ie_d;
    end
  end

  assign rd_data = rd_q;
  assign irq_fit = irq_fit_q;
  assign irq_pit = irq_pit_q;
  assign irq_wdg = irq_wdg_q;

  a_r2_tb_step: assert property (@(posedge clk) disable iff (rst)
    (tb_q != '1) |=> tb_q == $past(tb_q) + TB_W'(1));
  a_r9_clear_wins: assert property (@(posedge clk) disable iff (rst)
    wr_sts |=> ((tsr_q & $past(wr_data[TSR_W-1:0])) == '0));
  a_r7_arm_on_expiry: assert property (@(posedge clk) disable iff (rst)
    (wdg_fire && !tsr_clr[TSR_ARM]) |=> tsr_q[TSR_ARM]);
  a_r10_pit_gated: assert property (@(posedge clk) disable iff (rst)
    !tsr_q[TSR_PIT] |-> !irq_pit);
  a_r10_fit_gated: assert property (@(posedge clk) disable iff (rst)
    !tcr_q[CTL_FIT_IE] |-> !irq_fit);
  a_r11_ctl_store: assert property (@(posedge clk) disable iff (rst)
    wr_ctl |=> tcr_q == $past(wr_data));
endmodule

// File: tb/cpu_timer_unit_tb.sv
`timescale 1ns/1ps
module cpu_timer_unit_tb;
  localparam int FE = 3, WE = 5, ST = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [31:0] rd_data;
  logic irq_fit, irq_pit, irq_wdg;
  logic [1:0] rst_req;

  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  cpu_timer_unit #(.TB_W(32), .PIT_W(32), .FIT_EXP0(FE), .WDG_EXP0(WE), .EXP_STEP(ST)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq_fit(irq_fit), .irq_pit(irq_pit),
    .irq_wdg(irq_wdg), .rst_req(rst_req)
  );

  // behavioural reference model
  logic [31:0] m_tb, m_pit, m_rel, m_tcr, m_rd;
  logic [3:0]  m_tsr;
  logic [1:0]  m_rst;
  logic m_fprev, m_wprev, m_ifit, m_ipit, m_iwdg;

  always @(posedge clk) begin
    logic fb, wb, fe, we, pe;
    logic [3:0] setv, clrv;
    if (rst) begin
      m_tb = 0; m_pit = 0; m_rel = 0; m_tcr = 0; m_rd = 0; m_tsr = 0; m_rst = 0;
      m_fprev = 0; m_wprev = 0; m_ifit = 0; m_ipit = 0; m_iwdg = 0;
    end else begin
      case (rd_addr)
        2'd0: m_rd = m_pit;
        2'd1: m_rd = m_tcr;
        2'd2: m_rd = {28'd0, m_tsr};
        default: m_rd = m_tb;
      endcase
      fb = m_tb[FE - 1 + ST * int'(m_tcr[25:24])];
      wb = m_tb[WE - 1 + ST * int'(m_tcr[31:30])];
      fe = fb && !m_fprev;
      we = wb && !m_wprev;
      m_fprev = fb;
      m_wprev = wb;
      pe = 0;
      if (wr_en && wr_addr == 2'd0) begin
        m_pit = wr_data; m_rel = wr_data;
      end else if (m_pit == 1) begin
        pe = 1;
        m_pit = m_tcr[22] ? m_rel : 0;
      end else if (m_pit != 0) begin
        m_pit = m_pit - 1;
      end
      if (we && m_tsr[3] && m_rst == 0) m_rst = m_tcr[29:28];
      setv = {we, we, pe, fe};
      clrv = (wr_en && wr_addr == 2'd2) ? wr_data[3:0] : 4'd0;
      m_tsr = (m_tsr | setv) & ~clrv;
      if (wr_en && wr_addr == 2'd1) m_tcr = wr_data;
      m_tb = m_tb + 1;
      m_ifit = m_tsr[0] & m_tcr[23];
      m_ipit = m_tsr[1] & m_tcr[26];
      m_iwdg = m_tsr[2] & m_tcr[27];
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      chk(rd_data == m_rd, "R3 rd_data vs model", rd_data, m_rd);
      chk(irq_fit == m_ifit, "R6 irq_fit vs model", irq_fit, m_ifit);
      chk(irq_pit == m_ipit, "R5 irq_pit vs model", irq_pit, m_ipit);
      chk(irq_wdg == m_iwdg, "R7 irq_wdg vs model", irq_wdg, m_iwdg);
      chk(rst_req == m_rst, "R8 rst_req vs model", rst_req, m_rst);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a);
    rd_addr = a;
    @(negedge clk);
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_tb(input logic [31:0] n);
    while (m_tb != n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    run(2);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] x1;
    run(3);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(rd_data == 0 && !irq_fit && !irq_pit && !irq_wdg, "R1 outputs after reset",
        {rd_data, irq_fit, irq_pit, irq_wdg}, 0);
    chk(rst_req == 0, "R1 rst_req after reset", rst_req, 0);

    // R11 control word readback
    wr(2'd1, 32'h0012_3456);
    rd(2'd1);
    chk(rd_data == 32'h0012_3456, "R11 control readback", rd_data, 32'h0012_3456);

    // R2 time base step
    rd(2'd3); x1 = rd_data;
    rd(2'd3);
    chk(rd_data == x1 + 1, "R2 time base step", rd_data, x1 + 1);

    // R4 count down to zero and hold
    wr(2'd0, 32'd10);
    run(15);
    rd(2'd0);
    chk(rd_data == 0, "R4 count reached zero", rd_data, 0);
    run(5);
    rd(2'd0);
    chk(rd_data == 0, "R4 zero holds", rd_data, 0);
    chk(irq_pit == 1'b0, "R10 irq_pit masked", irq_pit, 0);
    rd(2'd2);
    chk(rd_data[1] == 1'b1, "R5 status bit set at zero", rd_data[1], 1);

    // R5 auto reload period
    wr(2'd2, 32'hFFFF_FFFF);
    wr(2'd1, (32'd1 << 22) | (32'd1 << 26));
    wr(2'd0, 32'd20);
    run(18);
    chk(irq_pit == 1'b0, "R5 no event before period", irq_pit, 0);
    run(1);
    chk(irq_pit == 1'b0, "R5 count at one", irq_pit, 0);
    run(1);
    chk(irq_pit == 1'b1, "R5 event after N clocks", irq_pit, 1);
    rd(2'd0);
    chk(rd_data == 32'd20, "R5 reload value taken", rd_data, 20);

    // R9 selective clear
    wr(2'd2, 32'h1);
    chk(irq_pit == 1'b1, "R9 zero bits untouched", irq_pit, 1);
    wr(2'd2, 32'h2);
    chk(irq_pit == 1'b0, "R9 one bit clears", irq_pit, 0);

    // R6 fixed timer sel 2: period 128, bit 6 rises at tb 64
    do_reset();
    wr(2'd1, (32'd2 << 24) | (32'd1 << 23));
    wait_tb(60);
    chk(irq_fit == 1'b0, "R6 before first rise", irq_fit, 0);
    wait_tb(66);
    chk(irq_fit == 1'b1, "R6 after first rise", irq_fit, 1);
    wr(2'd2, 32'h1);
    wait_tb(190);
    chk(irq_fit == 1'b0, "R6 quiet within period", irq_fit, 0);
    wait_tb(194);
    chk(irq_fit == 1'b1, "R6 next rise one period later", irq_fit, 1);

    // R7/R8 watchdog sel 0 (period 32, rises at 16, 48), chip reset
    do_reset();
    wr(2'd1, (32'd2 << 28) | (32'd1 << 27));
    wait_tb(18);
    chk(irq_wdg == 1'b1, "R7 first expiry interrupt", irq_wdg, 1);
    chk(rst_req == 2'd0, "R8 no request on first expiry", rst_req, 0);
    rd(2'd2);
    chk(rd_data[3:2] == 2'b11, "R7 status bits 3:2", rd_data[3:2], 3);
    wait_tb(52);
    chk(rst_req == 2'd2, "R8 second expiry requests", rst_req, 2);
    wr(2'd2, 32'hFFFF_FFFF);
    run(100);
    chk(rst_req == 2'd2, "R8 request sticky", rst_req, 2);

    // R8 type none
    do_reset();
    wr(2'd1, 32'd0);
    wait_tb(60);
    chk(rst_req == 2'd0, "R8 code 0 requests nothing", rst_req, 0);
    rd(2'd2);
    chk(rd_data[3:2] == 2'b11, "R8 armed with no request", rd_data[3:2], 3);

    // R9 clear beats same-cycle set (fixed sel 0: rises at 4, 12, 20)
    do_reset();
    wr(2'd1, 32'd1 << 23);
    wait_tb(8);
    wr(2'd2, 32'h1);
    wait_tb(12);
    wr(2'd2, 32'h1);
    chk(irq_fit == 1'b0, "R9 clear wins over set", irq_fit, 0);
    wait_tb(22);
    chk(irq_fit == 1'b1, "R9 later event sets again", irq_fit, 1);

    run(2);
    finish_run();
  end
endmodule